// File: doc/BRIEF.md
# Decoupled d-q Axis Current Regulator

This block closes the inner current loop of a grid-connected active rectifier in the rotating d-q frame. It works one sample at a time. When the sample strobe is high, it reads the d-axis current command, the measured d and q currents and the d and q grid-voltage components. From these it forms the two converter voltage commands that go to the modulator. The q-axis current command is fixed at zero internally, so the line current stays in phase with the grid voltage.

Each axis has a proportional-integral term. The integrator is clamped, and it stops accumulating while the output is pinned at its limit. Two further terms are added to each axis:
- a cross-coupling compensation: the other axis's measured current times an omega-L coefficient, with opposite signs on d and q;
- the grid-voltage feed-forward for that axis.

With these terms the two loops behave as independent first-order plants. Both axes use one shared set of gains. The proportional gain, the per-sample integral gain (Ki times the sample period) and the omega-L coefficient are written through a load strobe. The results are registered and appear one clock after the strobe, together with a valid flag.

Top module: `dq_curr_reg`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_vld` is 0, both voltage commands are 0 and both integrators hold 0.
- R2: `out_vld` is 1 in exactly the clock that follows a cycle with `smp_stb` high, and 0 otherwise. The voltage commands change only in that clock and hold their value until the next strobe.
- R3: Fixed-point conventions used below. Currents and voltages are two's-complement values with FRAC fractional bits. Gains have GFRAC fractional bits (4096 = 1.0 at the default GFRAC of 12). Every product is arithmetically shifted right by GFRAC bits, rounding toward minus infinity. With these conventions, the d command is P + I − ((wl·iq_meas)>>>GFRAC) + vg_d, where P = (kp·e)>>>GFRAC and e = id_ref − id_meas.
- R4: The q error is −iq_meas, because the q reference is zero. The q command is P + I + ((wl·id_meas)>>>GFRAC) + vg_q.
- R5: On each strobe, each integrator adds (ki·e)>>>GFRAC. The updated integrator value is the I term used for that same sample's output.
- R6: An integrator never leaves the range [−ILIM, +ILIM]. A sum beyond that range is clamped to the nearest limit.
- R7: Each voltage command is clamped to [−VMAX, +VMAX].
- R8: An integrator keeps its previous value when the unclamped output computed with the new integrator value would exceed +VMAX and the increment is positive. It also keeps its value when that output would fall below −VMAX and the increment is negative.
- R9: After reset the gains are KP_INIT, KI_INIT and WL_INIT. A load strobe replaces all three, and the new values apply to every sample strobe in a later cycle.
- R10: Both axes use the same kp, ki and wl values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe: process the current inputs |
| id_ref | input | DW | d-axis current command |
| id_meas | input | DW | Measured d-axis current |
| iq_meas | input | DW | Measured q-axis current |
| vg_d | input | DW | Grid voltage, d component (feed-forward) |
| vg_q | input | DW | Grid voltage, q component (feed-forward) |
| cfg_we | input | 1 | Load strobe for the three gain registers |
| cfg_kp | input | GW | Proportional gain to load |
| cfg_ki | input | GW | Per-sample integral gain to load |
| cfg_wl | input | GW | Omega-L coupling coefficient to load |
| vd_ref | output | DW | d-axis converter voltage command |
| vq_ref | output | DW | q-axis converter voltage command |
| out_vld | output | 1 | Commands updated in this cycle |

## Verification
An integrator that holds a wrong value shows up directly in the command of the very sample that uses it. Because the integrator state persists, the error stays visible on every later sample until the clamps hide it. The sweeps therefore rely on the bench's running integrator model: they never reset between samples, so one stray update causes miscompares from that sample onward. The clamp and hold paths are driven into their limits and out again, so a mistake in direction or limit changes the output within one or two samples. A sign error in the coupling term shows up on the first sample with a non-zero cross-axis current.

// File: rtl/dqreg_pkg.sv
package dqreg_pkg;
  // wide accumulator used for all intermediate sums
  localparam int ACC_W = 48;
  localparam int AX_D  = 0;
  localparam int AX_Q  = 1;
  localparam int N_AX  = 2;

  function automatic logic signed [ACC_W-1:0] clip_sym(
    input logic signed [ACC_W-1:0] v,
    input logic signed [ACC_W-1:0] lim
  );
    if (v > lim)       return lim;
    else if (v < -lim) return -lim;
    else               return v;
  endfunction
endpackage

// File: rtl/dqreg_cfg.sv
module dqreg_cfg #(
  parameter int GW      = 18,
  parameter int KP_INIT = 31949,
  parameter int KI_INIT = 41,
  parameter int WL_INIT = 2574
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic signed [GW-1:0] kp_in,
  input  logic signed [GW-1:0] ki_in,
  input  logic signed [GW-1:0] wl_in,
  output logic signed [GW-1:0] kp,
  output logic signed [GW-1:0] ki,
  output logic signed [GW-1:0] wl
);
  logic signed [GW-1:0] kp_q, ki_q, wl_q;
  logic signed [GW-1:0] kp_n, ki_n, wl_n;

  always_comb begin
    kp_n = kp_q;
    ki_n = ki_q;
    wl_n = wl_q;
    if (we) begin
      kp_n = kp_in;
      ki_n = ki_in;
      wl_n = wl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kp_q <= GW'(KP_INIT);
      ki_q <= GW'(KI_INIT);
      wl_q <= GW'(WL_INIT);
    end else begin
      kp_q <= kp_n;
      ki_q <= ki_n;
      wl_q <= wl_n;
    end
  end

  assign kp = kp_q;
  assign ki = ki_q;
  assign wl = wl_q;
endmodule

// File: rtl/dqreg_axis.sv
module dqreg_axis
  import dqreg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GW    = 18,
  parameter int GFRAC = 12,
  parameter int VMAX  = 6400,
  parameter int ILIM  = 4800,
  parameter bit XNEG  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW:0]   err,
  input  logic signed [DW-1:0] xcur,
  input  logic signed [DW-1:0] vg,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  input  logic signed [GW-1:0] wl,
  output logic signed [DW-1:0] u
);
  localparam logic signed [ACC_W-1:0] VMAX_A = ACC_W'(VMAX);
  localparam logic signed [ACC_W-1:0] ILIM_A = ACC_W'(ILIM);

  logic signed [DW-1:0]    integ_q, integ_n;
  logic signed [ACC_W-1:0] e_x, x_x, vg_x, kp_x, ki_x, wl_x, in_x;
  logic signed [ACC_W-1:0] p_t, inc_t, dec_raw, dec_t, cand, base, trial, u_wide;
  logic                    hold;

  always_comb begin
    e_x   = ACC_W'(err);
    x_x   = ACC_W'(xcur);
    vg_x  = ACC_W'(vg);
    kp_x  = ACC_W'(kp);
    ki_x  = ACC_W'(ki);
    wl_x  = ACC_W'(wl);
    in_x  = ACC_W'(integ_q);
    p_t     = (e_x * kp_x) >>> GFRAC;
    inc_t   = (e_x * ki_x) >>> GFRAC;
    dec_raw = (x_x * wl_x) >>> GFRAC;
    dec_t   = XNEG ? -dec_raw : dec_raw;
    cand    = clip_sym(in_x + inc_t, ILIM_A);
    base    = p_t + dec_t + vg_x;
    trial   = base + cand;
    hold    = ((trial > VMAX_A) && (inc_t > 0)) ||
              ((trial < -VMAX_A) && (inc_t < 0));
    integ_n = hold ? integ_q : cand[DW-1:0];
    u_wide  = clip_sym(base + ACC_W'(integ_n), VMAX_A);
    u       = u_wide[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  integ_q <= '0;
    else if (en) integ_q <= integ_n;
  end
endmodule

// File: rtl/dq_curr_reg.sv
module dq_curr_reg
  import dqreg_pkg::*;
#(
  parameter int DW      = 16,
  parameter int GW      = 18,
  parameter int GFRAC   = 12,
  parameter int VMAX    = 6400,
  parameter int ILIM    = 4800,
  parameter int KP_INIT = 31949,
  parameter int KI_INIT = 41,
  parameter int WL_INIT = 2574
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] id_ref,
  input  logic signed [DW-1:0] id_meas,
  input  logic signed [DW-1:0] iq_meas,
  input  logic signed [DW-1:0] vg_d,
  input  logic signed [DW-1:0] vg_q,
  input  logic                 cfg_we,
  input  logic signed [GW-1:0] cfg_kp,
  input  logic signed [GW-1:0] cfg_ki,
  input  logic signed [GW-1:0] cfg_wl,
  output logic signed [DW-1:0] vd_ref,
  output logic signed [DW-1:0] vq_ref,
  output logic                 out_vld
);
  logic signed [GW-1:0] kp, ki, wl;
  logic signed [DW:0]   err_a  [N_AX];
  logic signed [DW-1:0] xcur_a [N_AX];
  logic signed [DW-1:0] vg_a   [N_AX];
  logic signed [DW-1:0] u_a    [N_AX];

  logic signed [DW-1:0] vd_q, vq_q, vd_n, vq_n;
  logic                 vld_q, vld_n;

  dqreg_cfg #(
    .GW(GW), .KP_INIT(KP_INIT), .KI_INIT(KI_INIT), .WL_INIT(WL_INIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .kp_in(cfg_kp), .ki_in(cfg_ki), .wl_in(cfg_wl),
    .kp(kp), .ki(ki), .wl(wl)
  );

  // q-axis command is fixed at zero: its error is the negated measurement
  assign err_a[AX_D]  = (DW+1)'(id_ref) - (DW+1)'(id_meas);
  assign err_a[AX_Q]  = -((DW+1)'(iq_meas));
  assign xcur_a[AX_D] = iq_meas;
  assign xcur_a[AX_Q] = id_meas;
  assign vg_a[AX_D]   = vg_d;
  assign vg_a[AX_Q]   = vg_q;

  for (genvar ax = 0; ax < N_AX; ax++) begin : g_axis
    dqreg_axis #(
      .DW(DW), .GW(GW), .GFRAC(GFRAC), .VMAX(VMAX), .ILIM(ILIM),
      .XNEG(ax == AX_D)
    ) u_axis (
      .clk(clk), .rst_n(rst_n), .en(smp_stb),
      .err(err_a[ax]), .xcur(xcur_a[ax]), .vg(vg_a[ax]),
      .kp(kp), .ki(ki), .wl(wl),
      .u(u_a[ax])
    );
  end

  always_comb begin
    vld_n = smp_stb;
    vd_n  = smp_stb ? u_a[AX_D] : vd_q;
    vq_n  = smp_stb ? u_a[AX_Q] : vq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_q  <= '0;
      vq_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vd_q  <= vd_n;
      vq_q  <= vq_n;
      vld_q <= vld_n;
    end
  end

  assign vd_ref  = vd_q;
  assign vq_ref  = vq_q;
  assign out_vld = vld_q;
endmodule

// File: rtl/dq_curr_reg_chk.sv
module dq_curr_reg_chk #(
  parameter int DW   = 16,
  parameter int VMAX = 6400
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic                 out_vld,
  input logic signed [DW-1:0] vd_ref,
  input logic signed [DW-1:0] vq_ref
);
  localparam logic signed [DW-1:0] LIM = DW'(VMAX);

  // R2
  vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_vld);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_vld);

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(vd_ref) && $stable(vq_ref)));

  // R7
  d_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (vd_ref <= LIM && vd_ref >= -LIM));

  // R7
  q_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (vq_ref <= LIM && vq_ref >= -LIM));
endmodule

bind dq_curr_reg dq_curr_reg_chk #(.DW(DW), .VMAX(VMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .out_vld(out_vld),
  .vd_ref(vd_ref), .vq_ref(vq_ref)
);

// File: tb/dq_curr_reg_bench.sv
module dq_curr_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, GW = 18, GFRAC = 12, VMAX = 6400, ILIM = 4800;
  localparam int KP0 = 31949, KI0 = 41, WL0 = 2574;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_stb, cfg_we;
  logic signed [DW-1:0] id_ref, id_meas, iq_meas, vg_d, vg_q, vd_ref, vq_ref;
  logic signed [GW-1:0] cfg_kp, cfg_ki, cfg_wl;
  logic out_vld;

  longint m_id, m_iq, kp_m, ki_m, wl_m;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dq_curr_reg u_dq_curr_reg (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .id_ref(id_ref), .id_meas(id_meas), .iq_meas(iq_meas),
    .vg_d(vg_d), .vg_q(vg_q), .cfg_we(cfg_we),
    .cfg_kp(cfg_kp), .cfg_ki(cfg_ki), .cfg_wl(cfg_wl),
    .vd_ref(vd_ref), .vq_ref(vq_ref), .out_vld(out_vld)
  );

  function automatic longint clipl(longint v, longint l);
    if (v > l) return l;
    if (v < -l) return -l;
    return v;
  endfunction

  // per-axis model following R3..R8
  function automatic longint axis_m(longint e, longint x, bit neg, longint vg,
                                    inout longint integ);
    longint p, inc, dec, cand, base, trial;
    p    = (e * kp_m) >>> GFRAC;
    inc  = (e * ki_m) >>> GFRAC;
    dec  = (x * wl_m) >>> GFRAC;
    if (neg) dec = -dec;
    cand = clipl(integ + inc, ILIM);
    base = p + dec + vg;
    trial = base + cand;
    if (!((trial > VMAX && inc > 0) || (trial < -VMAX && inc < 0)))
      integ = cand;
    return clipl(base + integ, VMAX);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic load(int kp, int ki, int wl);
    @(negedge clk);
    cfg_kp = GW'(kp); cfg_ki = GW'(ki); cfg_wl = GW'(wl); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    kp_m = kp; ki_m = ki; wl_m = wl;
  endtask

  task automatic apply(string req, int idr, int idm, int iqm, int vgd, int vgq);
    longint ed, eq;
    @(negedge clk);
    id_ref = DW'(idr); id_meas = DW'(idm); iq_meas = DW'(iqm);
    vg_d = DW'(vgd); vg_q = DW'(vgq); smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    ed = axis_m(longint'(idr) - idm, iqm, 1'b1, vgd, m_id);
    eq = axis_m(-longint'(iqm), idm, 1'b0, vgq, m_iq);
    chk({req, " d"}, longint'(vd_ref), ed);
    chk({req, " q"}, longint'(vq_ref), eq);
    chk("R2 valid after strobe", longint'(out_vld), 1);
    // disturb inputs without a strobe: commands must hold (R2)
    id_ref = ~id_ref; iq_meas = ~iq_meas; vg_d = ~vg_d;
    @(negedge clk);
    chk("R2 valid idle", longint'(out_vld), 0);
    chk("R2 hold d", longint'(vd_ref), ed);
    chk("R2 hold q", longint'(vq_ref), eq);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_CYCLES) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual %0d expected <%0d cycles", cyc, WD_CYCLES);
      finish_run();
    end
  end

  initial begin
    int cur [5] = '{-700, -45, 0, 13, 650};
    int big [4] = '{-3000, -900, 1100, 3000};
    rst_n = 1'b0; smp_stb = 1'b0; cfg_we = 1'b0;
    id_ref = '0; id_meas = '0; iq_meas = '0; vg_d = '0; vg_q = '0;
    cfg_kp = '0; cfg_ki = '0; cfg_wl = '0;
    m_id = 0; m_iq = 0; kp_m = KP0; ki_m = KI0; wl_m = WL0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 vd", longint'(vd_ref), 0);
    chk("R1 vq", longint'(vq_ref), 0);
    chk("R1 vld", longint'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld after release", longint'(out_vld), 0);

    // R9: reset gains in use
    apply("R9 init gains", 100, 90, 3, 50, -20);
    apply("R9 init gains", -40, 10, -7, 300, 12);

    // R3 R4 R10: proportional + feed-forward + coupling, no integration
    load(4096, 0, 2048);
    foreach (cur[a]) foreach (cur[b])
      apply("R3 R4 prop sweep", cur[a], cur[b], cur[(a+b)%5], 40*a - 80, 17*b - 30);

    // R5: integration with coupling
    load(2048, 1024, 2574);
    foreach (cur[a]) foreach (cur[b])
      apply("R5 integ sweep", cur[a], cur[b], cur[b], -60, 25);

    // R6: integrator clamp at +ILIM/-ILIM without output saturation
    load(0, 4096, 0);
    for (int k = 0; k < 4; k++) apply("R6 clamp high", 2000, -2000, -2000, -4000, -4000);
    for (int k = 0; k < 6; k++) apply("R6 clamp low", -2000, 2000, 2000, 4000, 4000);

    // R7 R8: output saturation and integrator hold
    load(4096, 2048, 0);
    for (int k = 0; k < 5; k++) apply("R8 hold pos", 1500, -1500, -1500, 3000, 3000);
    for (int k = 0; k < 5; k++) apply("R8 hold neg", -1500, 1500, 1500, -3000, -3000);
    for (int k = 0; k < 4; k++) apply("R8 release", 0, 200, 200, 0, 0);

    // R7 R3 R4: mixed large sweep
    load(6000, 512, 4000);
    foreach (big[a]) foreach (big[b])
      apply("R7 large sweep", big[a], big[b], big[(a+1)%4], big[b], big[a]);

    finish_run();
  end
endmodule